// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of a three-channel, single-ended, 10-bit successive-approximation analog-to-digital converter. A CPU reaches it through a small APB-style register window. Software writes a settle count, then a single control word that selects a channel, turns the converter on and optionally enables the interrupt. The block then waits the programmed number of converter ticks and performs a ten-step binary search. On each step it drives a trial code to an external DAC and samples an external comparator.

When the search ends, the code is latched into the result register and the block sets the interrupt status. The interrupt line is asserted if it is enabled. A later control write of zero acknowledges the interrupt and turns the converter off. The converter clock is modelled as a one-cycle tick enable, produced by a fixed divider from the bus clock, so the whole block runs in one clock domain.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, every register reads zero, `irq` and `adc_pwr` are low, and `dac_code` is zero.
- R2: The result register at offset 0x00 returns the last completed code in bits 9:0, and bits 31:10 read zero. A conversion that does not complete leaves the result register unchanged.
- R3: A control write (offset 0x08) made while idle, with the power bit (bit 3) set, starts one conversion on the channel in bits 2:0. Busy (status offset 0x04, bit 0) then reads 1 until the code is latched, and busy is never 1 while the power bit is 0.
- R4: The settle count (offset 0x0C, bits 5:0, value D) is sampled at the start of a conversion. A conversion lasts D+10 converter ticks, and one tick occurs every TICK_DIV bus clocks.
- R5: The search starts at the most significant bit, with a first trial code of 0x200. It keeps each bit whose trial the comparator reports as at or above, so an input level v in 0..1023 yields the code v.
- R6: `adc_chan` follows control bits 2:0. Channel codes 3 to 7 are accepted and yield code 0.
- R7: On completion, the interrupt status (control bit 6) is set and reads 1. `irq` is high only when both the status and the enable (control bit 5) are 1.
- R8: A control write of zero, made while idle, clears the interrupt status, the enable, the power bit and the channel. `irq` then falls.
- R9: While busy, a control write with the power bit set is ignored. The control readback, the channel and the final code all remain those of the running conversion.
- R10: While busy, a control write with the power bit clear aborts the conversion: busy falls in the next cycle, the interrupt status is not set, and the result register keeps its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Register window selected |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 for a write transfer |
| paddr | input | 4 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high for a read |
| cmp_hi | input | 1 | Comparator: the sampled input is at or above the DAC level |
| dac_code | output | 10 | Trial code for the external DAC, zero outside the search |
| adc_chan | output | 3 | Channel select to the analog multiplexer |
| adc_pwr | output | 1 | Converter power enable |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
The assertions take for granted that `cmp_hi` is a pure function of the present `dac_code` and the selected channel. They also assume that a transfer keeps `paddr` and `pwdata` steady through its access phase and that the settle count is not rewritten while a conversion is running. The bench meets these conditions with a comparator model that evaluates continuously from its own per-channel input levels and with bus tasks that change the bus signals only on falling clock edges. Every settle-count write in the bench is made while the block is idle. Latency is checked as a window of bus cycles, because the phase of the free-running tick relative to the start write is not visible at the ports.

// File: rtl/sar_pkg.sv
// Package sar_pkg
// Shared register offsets, control-bit positions and the sequencer state
// type for the converter sequencer. Assumes a 4-bit byte address.
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_CONV   = 2'd2
    } sar_state_t;

    localparam logic [3:0] OFF_RESULT = 4'h0;
    localparam logic [3:0] OFF_STATUS = 4'h4;
    localparam logic [3:0] OFF_CTRL   = 4'h8;
    localparam logic [3:0] OFF_DELAY  = 4'hC;

    localparam int CTRL_IRQ_ST = 6;
    localparam int CTRL_IRQ_EN = 5;
    localparam int CTRL_PWR    = 3;
endpackage

// File: rtl/sar_tick_gen.sv
// Module sar_tick_gen
// Produces a one-cycle enable every DIV clocks. This enable is the
// converter tick. Assumes DIV >= 1. The tick runs freely; it does not
// restart when a conversion begins.
module sar_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Wrapping divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/sar_engine.sv
// Module sar_engine
// Settle-delay counter and binary-search sequencer. A start pulse loads
// the settle count. The engine then waits that many ticks and resolves
// one bit per tick, MSB first. done_now marks the tick that resolves the
// last bit, and final_code carries the completed code in that cycle.
// Assumes chan is held steady by the caller while busy, and that
// cmp_hi depends only on dac_code and the channel.
module sar_engine
    import sar_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int DLY_W  = 6,
    parameter int CH_W   = 3,
    parameter int NUM_CH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             abort,
    input  logic [DLY_W-1:0] dly,
    input  logic [CH_W-1:0]  chan,
    input  logic             cmp_hi,
    output logic             busy,
    output logic             done_now,
    output logic [RES_W-1:0] final_code,
    output logic [RES_W-1:0] dac_code
);
    localparam int IDX_W = $clog2(RES_W);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

    sar_state_t       state;
    logic [DLY_W-1:0] cnt;
    logic [RES_W-1:0] acc;
    logic [IDX_W-1:0] bit_idx;
    logic [RES_W-1:0] trial;
    logic             chan_ok;
    logic             keep;

    assign trial   = RES_W'(1) << bit_idx;
    assign chan_ok = (chan < CH_W'(NUM_CH));
    assign keep    = cmp_hi && chan_ok;

    // Sequencer: idle -> settle (D ticks) -> ten search ticks -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            acc     <= '0;
            bit_idx <= '0;
        end else if (abort) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    acc     <= '0;
                    bit_idx <= TOP_IDX;
                    cnt     <= dly;
                    state   <= (dly == '0) ? ST_CONV : ST_SETTLE;
                end
                ST_SETTLE: if (tick) begin
                    cnt <= cnt - 1'b1;
                    if (cnt == DLY_W'(1)) state <= ST_CONV;
                end
                ST_CONV: if (tick) begin
                    if (keep) acc <= acc | trial;
                    if (bit_idx == '0) state   <= ST_IDLE;
                    else               bit_idx <= bit_idx - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs: busy level, last-step strobe and code, and DAC trial code.
    always_comb begin
        busy       = (state != ST_IDLE);
        done_now   = (state == ST_CONV) && tick && (bit_idx == '0);
        final_code = keep ? (acc | trial) : acc;
        dac_code   = (state == ST_CONV) ? (acc | trial) : '0;
    end

    // R5: the first search step always trials the MSB alone.
    p_msb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && $past(state) != ST_CONV) |-> (dac_code == trial && bit_idx == TOP_IDX));

    // R6: a grounded channel never accumulates a bit.
    p_grounded_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !chan_ok) |-> (acc == '0));
endmodule

// File: rtl/sar_adc_ctrl.sv
// Module sar_adc_ctrl
// Register window and control policy for the converter sequencer. It
// decodes APB-style transfers (no wait states), holds the control,
// settle and result registers, and decides between start, abort and
// ignore on each control write. It also gates the interrupt.
// Assumes paddr and pwdata are stable during the access phase.
module sar_adc_ctrl
    import sar_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int RES_W    = 10,
    parameter int DLY_W    = 6,
    parameter int CH_W     = 3,
    parameter int NUM_CH   = 3,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              cmp_hi,
    output logic [RES_W-1:0]  dac_code,
    output logic [CH_W-1:0]   adc_chan,
    output logic              adc_pwr,
    output logic              irq
);
    logic             tick;
    logic             busy;
    logic             done_now;
    logic [RES_W-1:0] final_code;

    logic             irq_st;
    logic             irq_en;
    logic             pwr;
    logic [CH_W-1:0]  chan;
    logic [DLY_W-1:0] dly;
    logic [RES_W-1:0] result;

    logic wr, wr_ctrl, wr_dly, ctrl_take, start, abort;
    logic unused_wdata;

    assign unused_wdata = ^{pwdata[DATA_W-1:CTRL_IRQ_ST+1], pwdata[CTRL_PWR+1]};

    // Transfer decode and control-write policy.
    always_comb begin
        wr        = psel && penable && pwrite;
        wr_ctrl   = wr && (paddr == ADDR_W'(OFF_CTRL));
        wr_dly    = wr && (paddr == ADDR_W'(OFF_DELAY));
        ctrl_take = wr_ctrl && (!busy || !pwdata[CTRL_PWR]);
        start     = ctrl_take && pwdata[CTRL_PWR];
        abort     = ctrl_take && busy && !pwdata[CTRL_PWR];
    end

    sar_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    sar_engine #(
        .RES_W  (RES_W),
        .DLY_W  (DLY_W),
        .CH_W   (CH_W),
        .NUM_CH (NUM_CH)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .start      (start),
        .abort      (abort),
        .dly        (dly),
        .chan       (chan),
        .cmp_hi     (cmp_hi),
        .busy       (busy),
        .done_now   (done_now),
        .final_code (final_code),
        .dac_code   (dac_code)
    );

    // Control register: software fields, and the interrupt status set on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_st <= 1'b0;
            irq_en <= 1'b0;
            pwr    <= 1'b0;
            chan   <= '0;
        end else if (ctrl_take) begin
            irq_st <= irq_st & pwdata[CTRL_IRQ_ST];
            irq_en <= pwdata[CTRL_IRQ_EN];
            pwr    <= pwdata[CTRL_PWR];
            chan   <= pwdata[CH_W-1:0];
        end else if (done_now) begin
            irq_st <= 1'b1;
        end
    end

    // Settle-count register.
    always_ff @(posedge clk) begin
        if (!rst_n)      dly <= '0;
        else if (wr_dly) dly <= pwdata[DLY_W-1:0];
    end

    // Result register: loaded only by a completed, non-aborted search.
    always_ff @(posedge clk) begin
        if (!rst_n)                 result <= '0;
        else if (done_now && !abort) result <= final_code;
    end

    // Read mux.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (paddr)
                ADDR_W'(OFF_RESULT): prdata = DATA_W'(result);
                ADDR_W'(OFF_STATUS): prdata = DATA_W'(busy);
                ADDR_W'(OFF_CTRL):   prdata = DATA_W'({irq_st, irq_en, 1'b0, pwr, chan});
                ADDR_W'(OFF_DELAY):  prdata = DATA_W'(dly);
                default:             prdata = '0;
            endcase
        end
    end

    assign adc_chan = chan;
    assign adc_pwr  = pwr;
    assign irq      = irq_st && irq_en;

    // R3: the engine is never active with power off.
    p_busy_needs_pwr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> pwr);

    // R7: the interrupt status rises only as a conversion finishes.
    p_irq_on_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_st) |-> $fell(busy));

    // R8: an idle write of zero leaves everything off.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !busy && pwdata == '0) |=> (!irq_st && !adc_pwr && !irq));

    // R9: a power-on write during a conversion changes nothing.
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && busy && pwdata[CTRL_PWR]) |=> (chan == $past(chan) && irq_en == $past(irq_en) && busy));

    // R10: a power-off write during a conversion aborts it at once.
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && busy && !pwdata[CTRL_PWR]) |=> (!busy && !irq_st && $stable(result)));
endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
    localparam int DIV = 4;
    localparam logic [3:0] A_RES = 4'h0, A_STA = 4'h4, A_CTL = 4'h8, A_DLY = 4'hC;
    // {channel[2:0], input level[9:0], settle count[5:0]}
    localparam logic [18:0] VEC [8] = '{
        {3'd0, 10'd0,    6'd0},
        {3'd1, 10'd1023, 6'd63},
        {3'd2, 10'd512,  6'd8},
        {3'd0, 10'd511,  6'd1},
        {3'd1, 10'd341,  6'd8},
        {3'd2, 10'd682,  6'd2},
        {3'd5, 10'd700,  6'd8},
        {3'd3, 10'd1023, 6'd4}
    };

    logic        clk = 0, rst_n = 0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [3:0]  paddr = 0;
    logic [31:0] pwdata = 0, prdata;
    logic        cmp_hi, adc_pwr, irq;
    logic [9:0]  dac_code;
    logic [2:0]  adc_chan;
    logic [9:0]  vin [3];
    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    // Analog model: sample-and-hold, DAC and comparator; channels 3..7 grounded.
    assign cmp_hi = (adc_chan < 3'd3) ? (vin[adc_chan[1:0]] >= dac_code) : 1'b0;

    sar_adc_ctrl #(.TICK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cmp_hi(cmp_hi),
        .dac_code(dac_code), .adc_chan(adc_chan), .adc_pwr(adc_pwr), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        #1 d = prdata;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    // Counts bus cycles from the start write to the rise of irq.
    task automatic wait_irq(output int m);
        m = 0;
        while (!irq && m < 2000) begin @(negedge clk); m++; end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int m;
        vin[0] = 0; vin[1] = 0; vin[2] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        bus_read(A_RES, rd); check("R1 result", rd, 0);
        bus_read(A_STA, rd); check("R1 status", rd, 0);
        bus_read(A_CTL, rd); check("R1 ctrl", rd, 0);
        bus_read(A_DLY, rd); check("R1 delay", rd, 0);
        check("R1 irq/pwr/dac", {irq, adc_pwr, 22'd0, dac_code}, 0);

        // Vector table: R2 R4 R5 R6 R7 R8
        for (int i = 0; i < 8; i++) begin
            logic [2:0] ch; logic [9:0] v; logic [5:0] d; logic [9:0] exp;
            int lo, hi;
            ch = VEC[i][18:16]; v = VEC[i][15:6]; d = VEC[i][5:0];
            for (int k = 0; k < 3; k++) vin[k] = (ch < 3'd3) ? ~v : v;
            if (ch < 3'd3) vin[ch[1:0]] = v;
            exp = (ch < 3'd3) ? v : 10'd0;
            bus_write(A_DLY, 32'(d));
            bus_write(A_CTL, 32'h28 | 32'(ch));
            check("R6 adc_chan", 32'(adc_chan), 32'(ch));
            wait_irq(m);
            lo = (int'(d) + 9) * DIV + 1; hi = (int'(d) + 10) * DIV;
            check("R4 latency in window", 32'(m >= lo && m <= hi), 1);
            bus_read(A_RES, rd); check("R5 R6 R2 result code", rd, 32'(exp));
            bus_read(A_CTL, rd); check("R7 ctrl status bit6", rd, 32'h68 | 32'(ch));
            bus_read(A_STA, rd); check("R3 busy low after done", rd, 0);
            bus_write(A_CTL, 0);
            check("R8 irq low", 32'(irq), 0);
            bus_read(A_CTL, rd); check("R8 ctrl cleared", rd, 0);
        end

        // R3 and R9: busy during conversion; a power-on write is ignored
        vin[0] = 10'd300; vin[1] = 10'd900;
        bus_write(A_DLY, 32'd8);
        bus_write(A_CTL, 32'h28);
        bus_read(A_STA, rd); check("R3 busy during conversion", rd, 1);
        check("R3 adc_pwr", 32'(adc_pwr), 1);
        bus_write(A_CTL, 32'h29);
        bus_read(A_CTL, rd); check("R9 ctrl unchanged", rd, 32'h28);
        wait_irq(m);
        bus_read(A_RES, rd); check("R9 code from original channel", rd, 32'd300);
        bus_write(A_CTL, 0);

        // R10: abort
        bus_write(A_DLY, 32'd20);
        bus_write(A_CTL, 32'h29);
        bus_read(A_STA, rd); check("R10 busy before abort", rd, 1);
        bus_write(A_CTL, 0);
        bus_read(A_STA, rd); check("R10 busy after abort", rd, 0);
        repeat (200) @(negedge clk);
        check("R10 no irq", 32'(irq), 0);
        bus_read(A_CTL, rd); check("R10 status not set", rd, 0);
        bus_read(A_RES, rd); check("R10 result kept", rd, 32'd300);

        // R7: enable clear keeps irq low while the status sets
        vin[2] = 10'd77;
        bus_write(A_DLY, 32'd0);
        bus_write(A_CTL, 32'h0A);
        repeat (100) @(negedge clk);
        check("R7 irq gated", 32'(irq), 0);
        bus_read(A_CTL, rd); check("R7 status without enable", rd, 32'h4A);
        bus_read(A_RES, rd); check("R5 grounded-free code 77", rd, 32'd77);
        bus_write(A_CTL, 0);
        bus_read(A_CTL, rd); check("R8 clear after gated", rd, 0);

        finish_run();
    end
endmodule